// File: doc/BRIEF.md
# Cascaded Integrator-Comb Decimator

This block lowers the sample rate of a stream of signed samples by an integer ratio. It uses a cascade of running-sum stages at the input rate, then a cascade of first-difference stages at the output rate. A sample enters on any clock where the input strobe is high. Cycles with the strobe low are skipped entirely. After every `RATIO` accepted samples the block emits one filtered and decimated word together with a single-clock output strobe.

The raw filter gain is `RATIO^STAGES`. The block removes this gain by dividing by exactly that amount, rounding toward minus infinity, so that a constant input settles to the same constant at the output. The internal sums are wide enough to absorb the gain and wrap modulo their width without saturation. Wrapping is safe because the difference stages cancel it exactly. The output is therefore bit-exact against a plain integer model of the same sums, differences and floor division.

The stage count, ratio and sample width are parameters. The ratio is fixed at build time. A power-of-two ratio reduces the normalisation to an arithmetic shift.

Top module: `cic_decimator`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `out_valid` is 0 and `out_data` is 0. Reset clears every running sum, every difference-stage memory and the sample counter, so the first output after reset reflects exactly the `RATIO` samples accepted since then.
- R2: A sample is taken only on a rising clock edge where `in_valid` is 1. The value on `in_data` while `in_valid` is 0 has no effect on any later output.
- R3: Exactly one `out_valid` pulse is produced for every `RATIO` accepted samples. With the default ratio of 8, 256 accepted samples give exactly 32 outputs.
- R4: `out_valid` is high for exactly one clock. It is high during the cycle that follows the edge on which the `RATIO`-th sample of a group was accepted.
- R5: On each accepted sample, running sum 0 adds the sample. Each running sum k>0 then adds the already-updated value of sum k-1 in the same step.
- R6: At each decimation point, difference stage k outputs its input minus the input it held at the previous decimation point. Stage 0's input is the last running sum, and each later stage takes the output of the one before it.
- R7: The output equals the last difference divided by `RATIO^STAGES`, rounded toward minus infinity. For example, a single sample of -1 followed by seven zeros yields a first output of -1, and +1 followed by seven zeros yields 0.
- R8: Between pulses, `out_data` holds the value of the last output.
- R9: With a constant input held for at least `STAGES+1` output periods, the output equals that constant, including the full-scale values 32767 and -32768.
- R10: The running sums are `IN_W + STAGES*ceil(log2(RATIO))` bits wide and wrap with no saturation. Outputs stay bit-exact over long runs of full-scale random input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | IN_W | Signed two's-complement input sample |
| out_valid | output | 1 | One-clock strobe marking a new output word |
| out_data | output | IN_W | Signed two's-complement decimated output |

## Verification
The sharpest corner case is floor rounding on small negative results. A design that truncates toward zero returns 0 for the single -1 impulse, where -1 is required. A design that adds the stale value of the previous running sum, rather than the updated one, produces a different impulse response, and the ramp and random runs diverge from the integer model on the first output. Gaps in the strobe that carry full-scale junk data catch a design that integrates regardless of the strobe. A reset in the middle of a group catches a counter or difference memory that survives reset, because the first output then arrives early or carries the old history. Long full-scale random runs force the running sums to wrap, so a design with too few bits, or one that saturates, fails the comparison.

// File: rtl/cic_pkg.sv
package cic_pkg;

    // Integer power used to form the DC gain of the filter.
    function automatic longint ipow(input int base, input int expo);
        longint acc;
        acc = 1;
        for (int i = 0; i < expo; i++) begin
            acc = acc * base;
        end
        return acc;
    endfunction

    function automatic bit is_pow2(input int v);
        return (v > 0) && ((v & (v - 1)) == 0);
    endfunction

endpackage

// File: rtl/cic_integ_chain.sv
module cic_integ_chain #(
    parameter int IN_W   = 16,
    parameter int STAGES = 3,
    parameter int ACC_W  = 25
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic signed [IN_W-1:0]  in_data,
    output logic signed [ACC_W-1:0] last_next
);

    typedef struct packed {
        logic [STAGES-1:0][ACC_W-1:0] acc;
    } integ_st_t;

    integ_st_t st_d, st_q;

    always_comb begin
        logic signed [ACC_W-1:0] run;
        st_d = st_q;
        run  = {{(ACC_W-IN_W){in_data[IN_W-1]}}, in_data};
        for (int s = 0; s < STAGES; s++) begin
            run = st_q.acc[s] + run;
            if (in_valid) begin
                st_d.acc[s] = run;
            end
        end
        last_next = run;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/cic_decim_count.sv
module cic_decim_count #(
    parameter int RATIO = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    output logic tick
);

    localparam int CNT_W = (RATIO > 1) ? $clog2(RATIO) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(RATIO - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        tick = in_valid && (st_q.cnt == LAST);
        if (in_valid) begin
            st_d.cnt = tick ? '0 : st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/cic_comb_chain.sv
module cic_comb_chain #(
    parameter int STAGES = 3,
    parameter int ACC_W  = 25
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    take,
    input  logic signed [ACC_W-1:0] samp,
    output logic signed [ACC_W-1:0] result
);

    typedef struct packed {
        logic [STAGES-1:0][ACC_W-1:0] dly;
    } comb_st_t;

    comb_st_t st_d, st_q;

    always_comb begin
        logic signed [ACC_W-1:0] x;
        logic signed [ACC_W-1:0] y;
        st_d = st_q;
        x    = samp;
        for (int s = 0; s < STAGES; s++) begin
            y = x - st_q.dly[s];
            if (take) begin
                st_d.dly[s] = x;
            end
            x = y;
        end
        result = x;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/cic_normalize.sv
module cic_normalize
    import cic_pkg::*;
#(
    parameter int IN_W   = 16,
    parameter int STAGES = 3,
    parameter int RATIO  = 8,
    parameter int ACC_W  = 25
) (
    input  logic signed [ACC_W-1:0] din,
    output logic signed [IN_W-1:0]  dout
);

    generate
        if (is_pow2(RATIO)) begin : g_shift
            localparam int SHIFT = STAGES * $clog2(RATIO);
            always_comb begin
                dout = IN_W'(din >>> SHIFT);
            end
        end else begin : g_divide
            localparam logic signed [ACC_W:0] GAIN = (ACC_W+1)'(ipow(RATIO, STAGES));
            logic signed [ACC_W:0] wide;
            logic signed [ACC_W:0] quot;
            logic signed [ACC_W:0] rem;
            logic signed [ACC_W:0] fixed;
            always_comb begin
                wide  = {din[ACC_W-1], din};
                quot  = wide / GAIN;
                rem   = wide % GAIN;
                fixed = ((rem != 0) && wide[ACC_W]) ? quot - 1'b1 : quot;
                dout  = IN_W'(fixed);
            end
        end
    endgenerate

endmodule

// File: rtl/cic_decimator.sv
module cic_decimator #(
    parameter int IN_W   = 16,
    parameter int STAGES = 3,
    parameter int RATIO  = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic signed [IN_W-1:0] in_data,
    output logic                   out_valid,
    output logic signed [IN_W-1:0] out_data
);

    localparam int GROWTH = STAGES * ((RATIO > 1) ? $clog2(RATIO) : 1);
    localparam int ACC_W  = IN_W + GROWTH;

    typedef struct packed {
        logic            valid;
        logic [IN_W-1:0] data;
    } out_st_t;

    logic signed [ACC_W-1:0] integ_last;
    logic signed [ACC_W-1:0] comb_out;
    logic signed [IN_W-1:0]  norm_out;
    logic                    tick;
    out_st_t                 o_d, o_q;

    cic_integ_chain #(.IN_W(IN_W), .STAGES(STAGES), .ACC_W(ACC_W)) u_integ (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .last_next (integ_last)
    );

    cic_decim_count #(.RATIO(RATIO)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .tick     (tick)
    );

    cic_comb_chain #(.STAGES(STAGES), .ACC_W(ACC_W)) u_comb (
        .clk    (clk),
        .rst_n  (rst_n),
        .take   (tick),
        .samp   (integ_last),
        .result (comb_out)
    );

    cic_normalize #(.IN_W(IN_W), .STAGES(STAGES), .RATIO(RATIO), .ACC_W(ACC_W)) u_norm (
        .din  (comb_out),
        .dout (norm_out)
    );

    always_comb begin
        o_d       = o_q;
        o_d.valid = tick;
        if (tick) begin
            o_d.data = norm_out;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign out_valid = o_q.valid;
    assign out_data  = o_q.data;

endmodule

// File: rtl/cic_decimator_chk.sv
module cic_decimator_chk #(
    parameter int IN_W  = 16,
    parameter int RATIO = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic            out_valid,
    input logic [IN_W-1:0] out_data
);

    int   seen_q;
    logic due_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= 0;
            due_q  <= 1'b0;
        end else begin
            due_q <= in_valid && (seen_q == RATIO - 1);
            if (in_valid) begin
                seen_q <= (seen_q == RATIO - 1) ? 0 : seen_q + 1;
            end
        end
    end

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);                                  // R4
    AST_ONE_PER_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == due_q);                                        // R3
    AST_STROBE_NEEDS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid));                             // R2
    AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_data));                          // R8

endmodule

bind cic_decimator cic_decimator_chk #(.IN_W(IN_W), .RATIO(RATIO)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/cic_decimator_tb.sv
module cic_decimator_tb;

    localparam int W = 16;
    localparam int N = 3;
    localparam int D = 8;
    localparam time CLK_PER = 20ns;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                in_valid = 1'b0;
    logic signed [W-1:0] in_data = '0;
    logic                out_valid;
    logic signed [W-1:0] out_data;

    int     n_chk = 0;
    int     n_fail = 0;
    bit     done = 0;
    longint integ [N];
    longint dly [N];
    int     cnt;
    longint gain;
    longint last_exp;
    int     n_out;

    cic_decimator #(.IN_W(W), .STAGES(N), .RATIO(D)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    always #(CLK_PER/2) clk = ~clk;

    function automatic longint fdiv(input longint a, input longint b);
        longint q;
        q = a / b;
        if ((a % b) != 0 && a < 0) q = q - 1;
        return q;
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_clear();
        for (int s = 0; s < N; s++) begin
            integ[s] = 0;
            dly[s]   = 0;
        end
        cnt      = 0;
        last_exp = 0;
        n_out    = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n    = 1'b0;
        in_valid = 1'b0;
        in_data  = '0;
        repeat (3) @(negedge clk);
        model_clear();
        rst_n = 1'b1;
    endtask

    // One clock of stimulus, with the model stepped alongside and the outputs checked.
    task automatic step(input bit v, input logic signed [W-1:0] x, input string req);
        bit     fire;
        longint run;
        longint tmp;
        fire = 0;
        @(negedge clk);
        in_valid = v;
        in_data  = x;
        if (v) begin
            run = longint'(x);
            for (int s = 0; s < N; s++) begin
                integ[s] = integ[s] + run;
                run      = integ[s];
            end
            cnt++;
            if (cnt == D) begin
                cnt  = 0;
                fire = 1;
                run  = integ[N-1];
                for (int s = 0; s < N; s++) begin
                    tmp    = run - dly[s];
                    dly[s] = run;
                    run    = tmp;
                end
                last_exp = fdiv(run, gain);
            end
        end
        @(posedge clk);
        #1;
        if (fire) begin
            n_out++;
            check(out_valid === 1'b1, {req, " strobe"}, longint'(out_valid), 1);
            check($signed(out_data) == last_exp, {req, " data"}, longint'(out_data), last_exp);
        end else begin
            check(out_valid === 1'b0, {req, " quiet R4"}, longint'(out_valid), 0);
            check($signed(out_data) == last_exp, {req, " hold R8"}, longint'(out_data), last_exp);
        end
    endtask

    task automatic t_reset_state();
        do_reset();
        check(out_valid === 1'b0, "R1 valid in reset", longint'(out_valid), 0);
        @(posedge clk);
        #1;
        check(out_valid === 1'b0, "R1 valid after reset", longint'(out_valid), 0);
        check(out_data == 0, "R1 data after reset", longint'(out_data), 0);
    endtask

    task automatic t_ramp();
        do_reset();
        for (int i = 0; i < 256; i++) step(1'b1, W'(i), "R5 R6 ramp");
        check(n_out == 32, "R3 count over 256", n_out, 32);
    endtask

    task automatic t_floor();
        do_reset();
        step(1'b1, -16'sd1, "R7 neg impulse");
        for (int i = 0; i < D - 1; i++) step(1'b1, '0, "R7 neg impulse");
        check($signed(out_data) == -1, "R7 floor of negative", longint'(out_data), -1);
        do_reset();
        step(1'b1, 16'sd1, "R7 pos impulse");
        for (int i = 0; i < D - 1; i++) step(1'b1, '0, "R7 pos impulse");
        check($signed(out_data) == 0, "R7 floor of positive", longint'(out_data), 0);
    endtask

    task automatic t_const(input logic signed [W-1:0] k);
        do_reset();
        for (int i = 0; i < D * (N + 3); i++) step(1'b1, k, "R9 constant");
        check($signed(out_data) == longint'(k), "R9 unity DC gain", longint'(out_data), longint'(k));
    endtask

    task automatic t_gaps();
        do_reset();
        for (int i = 0; i < 120; i++) begin
            step(1'b1, W'(i * 37 - 900), "R2 gapped");
            if (i % 3 == 0) step(1'b0, 16'sh7fff, "R2 junk ignored");
            if (i % 7 == 0) step(1'b0, -16'sh8000, "R2 junk ignored");
        end
        check(n_out == 15, "R3 count with gaps", n_out, 15);
    endtask

    task automatic t_hold();
        do_reset();
        for (int i = 0; i < D; i++) step(1'b1, 16'sd3000, "R4 group");
        step(1'b0, '0, "R4 pulse ends");
        check(out_valid === 1'b0, "R4 single cycle pulse", longint'(out_valid), 0);
        repeat (5) step(1'b0, 16'sh1234, "R8 idle");
        check($signed(out_data) == last_exp, "R8 held value", longint'(out_data), last_exp);
    endtask

    task automatic t_mid_reset();
        do_reset();
        for (int i = 0; i < 5; i++) step(1'b1, 16'sd20000, "R1 partial group");
        do_reset();
        for (int i = 0; i < D - 1; i++) step(1'b1, 16'sd7, "R1 fresh group");
        check(out_valid === 1'b0 && n_out == 0, "R1 no early output", n_out, 0);
        step(1'b1, 16'sd7, "R1 first after reset");
        check(n_out == 1, "R1 output on D-th input", n_out, 1);
    endtask

    task automatic t_random_wrap();
        logic signed [W-1:0] r;
        do_reset();
        for (int i = 0; i < 4000; i++) begin
            r = W'($urandom);
            if (i % 2 == 0) r = r[W-1] ? -16'sh8000 : 16'sh7fff;
            step(($urandom % 4) != 0, r, "R10 random full scale");
        end
        check(n_out > 300, "R10 outputs produced", n_out, 300);
    endtask

    initial begin
        gain = 1;
        for (int i = 0; i < N; i++) gain = gain * D;
        model_clear();
        t_reset_state();
        t_ramp();
        t_floor();
        t_const(-16'sd1234);
        t_const(16'sh7fff);
        t_const(-16'sh8000);
        t_gaps();
        t_hold();
        t_mid_reset();
        t_random_wrap();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(CLK_PER * 150000);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

endmodule